// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Loader

This block is the digital front end for a pair of 12-bit converter channels. A host drives an 8-bit parallel bus together with a 2-bit register select, an active-low chip select, write strobe and update strobe, and an active-low clear. Each channel's 12-bit code is built up in a first-rank input register from two writes: a low byte and a right-justified high nibble. A second-rank output register per channel drives the code outputs. Holding update low during a write copies both input registers into both output registers on one clock edge, so both channels move together.

All bus inputs are brought into the system clock domain through two-stage synchronisers. The block acts once per write strobe, on the write strobe's falling edge as seen after synchronisation. The select, data, chip select and update levels are sampled at that moment. When chip select and update are both low, the written value reaches the output register in the same cycle as the input register, which makes the path transparent. The clear input resets every register at once, without waiting for the clock. Its release is synchronised, so the registers leave reset on a clock edge.

The bus has no flow control. The host meets the timing given in the requirements: every bus signal is stable for at least two clock cycles before the write strobe falls, and the strobe stays low for at least three clock cycles.

Top module: `dual_code_loader`

## Requirements
- R1: A write with `bus_sel` = 2'b00 (channel A) or 2'b10 (channel B) and chip select low stores `bus_d[7:0]` into bits 7..0 of that channel's input register.
- R2: A write with `bus_sel` = 2'b01 (channel A) or 2'b11 (channel B) and chip select low stores `bus_d[3:0]` into bits 11..8 of that channel's input register. Bus bits 7..4 are ignored.
- R3: A write with `cs_n` high and `upd_n` high changes no register and no output.
- R4: A write with `upd_n` low copies both input registers into both output registers on the same clock edge, whatever the level of `cs_n`.
- R5: A write with `cs_n` and `upd_n` both low updates the selected part of the input register and drives the resulting code onto the output in that same cycle.
- R6: While `upd_n` stays high, writes to the input registers leave `code_a` and `code_b` unchanged.
- R7: A write strobe that is held low acts exactly once. Changes to the bus while the strobe is held low have no effect.
- R8: Driving `clr_n` low zeroes every input and output register at once, with no clock needed. After release, the registers stay at zero until a write.
- R9: If `wr_n` is first seen low at rising edge E1, the outputs change at rising edge E3 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| bus_d | input | 8 | Parallel data bus |
| bus_sel | input | 2 | Register select: bit 1 picks channel B, bit 0 picks the high nibble |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| upd_n | input | 1 | Update strobe, active low |
| code_a | output | 12 | Output register of channel A |
| code_b | output | 12 | Output register of channel B |

## Verification
The bound checker checks three things on every cycle. Outputs are zero while clear is low. Outputs hold still once the update strobe has been high for several cycles. Outputs hold still once the write strobe has stayed at one level for several cycles, which covers both the idle bus and a held-low strobe. Nibble placement, the chip-select gating and transparent pass-through need known data values, so only the bench's scenarios can show them. The same is true of both channels moving on one edge, the exact three-edge latency, and registers that hold zero after clear is released.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  typedef enum logic [1:0] {
    SEL_A_LO = 2'b00,
    SEL_A_HI = 2'b01,
    SEL_B_LO = 2'b10,
    SEL_B_HI = 2'b11
  } sel_e;

  typedef struct packed {
    logic load;     // write an input register
    logic xfer;     // copy input rank to output rank
    logic chan_b;   // target channel B
    logic hi_part;  // target high nibble
  } cmd_t;
endpackage

// File: rtl/dcl_sync.sv
module dcl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= RST_VAL;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dcl_cmd_decode.sv
module dcl_cmd_decode
  import dcl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_n_s,
  input  logic       cs_n_s,
  input  logic       upd_n_s,
  input  logic [1:0] sel_s,
  output cmd_t       cmd
);
  logic wr_n_d;
  logic fire;
  sel_e sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_n_d <= 1'b1;
    else        wr_n_d <= wr_n_s;
  end

  // one action per strobe: only the high-to-low step counts
  assign fire = wr_n_d & ~wr_n_s;
  assign sel  = sel_e'(sel_s);

  always_comb begin
    cmd.load    = fire & ~cs_n_s;
    cmd.xfer    = fire & ~upd_n_s;
    cmd.chan_b  = (sel == SEL_B_LO) || (sel == SEL_B_HI);
    cmd.hi_part = (sel == SEL_A_HI) || (sel == SEL_B_HI);
  end
endmodule

// File: rtl/dcl_channel.sv
module dcl_channel #(
  parameter int CODE_W = 12,
  parameter int BUS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              xfer,
  input  logic [BUS_W-1:0]  din,
  output logic [CODE_W-1:0] code
);
  localparam int HI_W = CODE_W - BUS_W;

  logic [CODE_W-1:0] in_q, in_nxt, out_q;

  always_comb begin
    in_nxt = in_q;
    if (ld_lo) in_nxt[BUS_W-1:0] = din;
    if (ld_hi) in_nxt[CODE_W-1:BUS_W] = din[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      in_q <= in_nxt;
      if (xfer) out_q <= in_nxt;  // transparent when load and xfer coincide
    end
  end

  assign code = out_q;
endmodule

// File: rtl/dual_code_loader.sv
module dual_code_loader
  import dcl_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BUS_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic [BUS_W-1:0]  bus_d,
  input  logic [1:0]        bus_sel,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              upd_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  localparam int NCH = 2;
  localparam int SW = BUS_W + 5;
  localparam logic [SW-1:0] SYNC_RST = SW'(3'b111);

  logic              rst_n_i;
  logic [SW-1:0]     bus_s;
  logic [BUS_W-1:0]  d_s;
  logic [1:0]        sel_s;
  logic              cs_n_s, upd_n_s, wr_n_s;
  cmd_t              cmd;
  logic [CODE_W-1:0] codes [NCH];

  // clear asserts at once, releases on a clock edge
  dcl_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(clr_n), .d(1'b1), .q(rst_n_i)
  );

  dcl_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_bus_sync (
    .clk(clk), .rst_n(rst_n_i),
    .d({bus_sel, bus_d, cs_n, upd_n, wr_n}), .q(bus_s)
  );

  assign {sel_s, d_s, cs_n_s, upd_n_s, wr_n_s} = bus_s;

  dcl_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n_i), .wr_n_s(wr_n_s), .cs_n_s(cs_n_s),
    .upd_n_s(upd_n_s), .sel_s(sel_s), .cmd(cmd)
  );

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic hit;
      assign hit = cmd.load & (cmd.chan_b == (ch == 1));
      dcl_channel #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_chan (
        .clk(clk), .rst_n(rst_n_i),
        .ld_lo(hit & ~cmd.hi_part), .ld_hi(hit & cmd.hi_part),
        .xfer(cmd.xfer), .din(d_s), .code(codes[ch])
      );
    end
  endgenerate

  assign code_a = codes[0];
  assign code_b = codes[1];
endmodule

// File: rtl/dual_code_loader_chk.sv
module dual_code_loader_chk #(
  parameter int CODE_W = 12,
  parameter int SETTLE = 5
) (
  input logic              clk,
  input logic              clr_n,
  input logic              wr_n,
  input logic              upd_n,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b
);
  logic [3:0] upd_hi_cnt, wr_hi_cnt, wr_lo_cnt;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      upd_hi_cnt <= '0;
      wr_hi_cnt  <= '0;
      wr_lo_cnt  <= '0;
    end else begin
      upd_hi_cnt <= !upd_n ? '0 : (upd_hi_cnt == 4'hF ? upd_hi_cnt : upd_hi_cnt + 4'd1);
      wr_hi_cnt  <= !wr_n  ? '0 : (wr_hi_cnt  == 4'hF ? wr_hi_cnt  : wr_hi_cnt  + 4'd1);
      wr_lo_cnt  <=  wr_n  ? '0 : (wr_lo_cnt  == 4'hF ? wr_lo_cnt  : wr_lo_cnt  + 4'd1);
    end
  end

  always @(posedge clk) begin
    if (!clr_n) begin
      AST_CLEAR_ZEROES: assert (code_a == '0 && code_b == '0) else $error("outputs not zero in clear"); // R8
    end
  end

  AST_UPD_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!clr_n)
    (upd_hi_cnt >= 4'(SETTLE)) |-> ($stable(code_a) && $stable(code_b))) else $error("output moved with update high"); // R6

  AST_HELD_WRITE_ONCE: assert property (@(posedge clk) disable iff (!clr_n)
    (wr_lo_cnt >= 4'(SETTLE)) |-> ($stable(code_a) && $stable(code_b))) else $error("held strobe acted again"); // R7

  AST_IDLE_BUS_HOLDS: assert property (@(posedge clk) disable iff (!clr_n)
    (wr_hi_cnt >= 4'(SETTLE)) |-> ($stable(code_a) && $stable(code_b))) else $error("output moved with no write"); // R3
endmodule

bind dual_code_loader dual_code_loader_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .clr_n(clr_n), .wr_n(wr_n), .upd_n(upd_n),
  .code_a(code_a), .code_b(code_b)
);

// File: tb/dual_code_loader_bench.sv
module dual_code_loader_bench;
  logic        clk = 1'b0;
  logic        clr_n = 1'b0;
  logic [7:0]  bus_d = '0;
  logic [1:0]  bus_sel = '0;
  logic        cs_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1;
  logic [11:0] code_a, code_b;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  dual_code_loader u_dual_code_loader (
    .clk(clk), .clr_n(clr_n), .bus_d(bus_d), .bus_sel(bus_sel),
    .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n), .code_a(code_a), .code_b(code_b)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [7:0]  d;
    logic        cs;
    logic        upd;
    logic [11:0] ea;
    logic [11:0] eb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h34, 1'b0, 1'b1, 12'h000, 12'h000},  // R1 R6 A low, no update
    '{2'd1, 8'hF2, 1'b0, 1'b1, 12'h000, 12'h000},  // R2 A high, upper bits junk
    '{2'd2, 8'hCD, 1'b0, 1'b1, 12'h000, 12'h000},  // R1 B low
    '{2'd3, 8'h5B, 1'b0, 1'b1, 12'h000, 12'h000},  // R2 B high
    '{2'd0, 8'h00, 1'b1, 1'b0, 12'h234, 12'hBCD},  // R4 update only
    '{2'd0, 8'hAA, 1'b0, 1'b0, 12'h2AA, 12'hBCD},  // R5 transparent A low
    '{2'd3, 8'h01, 1'b0, 1'b0, 12'h2AA, 12'h1CD},  // R5 transparent B high
    '{2'd0, 8'hFF, 1'b1, 1'b1, 12'h2AA, 12'h1CD},  // R3 not selected
    '{2'd1, 8'h07, 1'b0, 1'b1, 12'h2AA, 12'h1CD},  // R6 load, no update
    '{2'd0, 8'h00, 1'b1, 1'b0, 12'h7AA, 12'h1CD}   // R4 update only
  };

  task automatic check(input string req, input logic [11:0] a, input logic [11:0] b,
                       input logic [11:0] ea, input logic [11:0] eb);
    checks++;
    if (a !== ea || b !== eb) begin
      fails++;
      $display("FAIL %s: got a=%h b=%h expected a=%h b=%h", req, a, b, ea, eb);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [7:0] d, input logic c, input logic u);
    @(negedge clk);
    bus_sel = s; bus_d = d; cs_n = c; upd_n = u;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    repeat (6) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1; upd_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: got cycle=%0d expected below 20000", cyc);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset", code_a, code_b, 12'h000, 12'h000);
    clr_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i].sel, VEC[i].d, VEC[i].cs, VEC[i].upd);
      check($sformatf("R1-table vector %0d", i), code_a, code_b, VEC[i].ea, VEC[i].eb);
    end

    // stage new input values for the same-edge check
    bus_write(2'd0, 8'h55, 1'b0, 1'b1);
    bus_write(2'd3, 8'h03, 1'b0, 1'b1);
    check("R6 staged", code_a, code_b, 12'h7AA, 12'h1CD);

    // R4 and R9: both channels move together at E3, not at E2
    @(negedge clk);
    cs_n = 1'b1; upd_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 before E3", code_a, code_b, 12'h7AA, 12'h1CD);
    @(posedge clk); @(negedge clk);
    check("R4 R9 same edge", code_a, code_b, 12'h755, 12'h3CD);
    repeat (4) @(negedge clk);
    wr_n = 1'b1; upd_n = 1'b1;
    repeat (6) @(negedge clk);

    // R7: held strobe, bus changes while low
    bus_sel = 2'd0; bus_d = 8'h11; cs_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    repeat (6) @(negedge clk);
    bus_sel = 2'd2; bus_d = 8'h22;
    repeat (10) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (6) @(negedge clk);
    bus_write(2'd0, 8'h00, 1'b1, 1'b0);
    check("R7 held write", code_a, code_b, 12'h711, 12'h3CD);

    // R8: clear without a clock edge, then registers stay zero
    @(negedge clk);
    #1 clr_n = 1'b0;
    #1 check("R8 async clear", code_a, code_b, 12'h000, 12'h000);
    repeat (3) @(negedge clk);
    clr_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 after release", code_a, code_b, 12'h000, 12'h000);
    bus_write(2'd0, 8'h00, 1'b1, 1'b0);
    check("R8 inputs cleared", code_a, code_b, 12'h000, 12'h000);

    // R2 nibble ignore with transparent path
    bus_write(2'd1, 8'hA9, 1'b0, 1'b0);
    check("R2 R5 high nibble", code_a, code_b, 12'h900, 12'h000);
    // R3: cs high with update high changes nothing
    bus_write(2'd1, 8'h04, 1'b1, 1'b1);
    check("R3 ignored", code_a, code_b, 12'h900, 12'h000);

    summary();
  end
endmodule